// File: doc/BRIEF.md
# Single-Wire Bus Bit Master

This block is the bit-level master for an open-drain single-wire bus. A host reaches it through a small register port: read enable, write enable, an address, an 8-bit write word and an 8-bit read word. One control write starts one bus operation. That operation is either a bus reset with a presence check, or a single time slot that writes one bit to the wire or reads one bit back from it. Byte assembly and device command sets belong to the host. The host sends multi-bit commands least significant bit first, one slot per bit.

All bus timing comes from the system clock (50 MHz by default) through a divider that produces one tick per microsecond. The block pulls the wire low by raising `line_oe`. The pad outside the block turns that into a hard 0, and into high impedance when `line_oe` is low. The wire level comes back on `line_in` through a two-stage synchronizer. Bit 0 of the read word holds the last presence result or the last bit read. Bit 1 of the read word is a busy flag.

Top module: `ow_bus_master`

## Requirements
- R1: Only writes to address 0 are decoded. Control value 8'h0A starts a bus reset. 8'h00 starts a write slot for bit 0 and 8'h01 starts a write slot for bit 1, so the data bit is bit 0 of the word. 8'h02 starts a read slot. Any other value, and any write to another address, is ignored: the busy flag stays 0 and the line stays released.
- R2: Every interval of N microseconds lasts exactly N × CLK_PER_US clock cycles, counted from the clock edge that accepts the control write. No extra cycles are added for zero detection or for state changes. The default CLK_PER_US is 50.
- R3: A bus reset holds `line_oe` high for 480 µs (24000 cycles) and keeps the block busy for 960 µs in total (48000 cycles).
- R4: During a bus reset the line is sampled 550 µs after the start. Read bit 0 then becomes 0 if the line was low (a device answered) and 1 if it was high (no device).
- R5: A write slot keeps the block busy for 65 µs (3250 cycles). It holds `line_oe` high for 6 µs (300 cycles) to send a 1 and for 60 µs (3000 cycles) to send a 0. It leaves read bit 0 unchanged.
- R6: A read slot keeps the block busy for 65 µs. It holds `line_oe` high for 6 µs, samples the line 15 µs after the start, and stores the sample in read bit 0.
- R7: Read bit 1 (busy) is 1 from the accepting edge until the operation ends. Any control write that arrives while busy is 1 is ignored. This includes a write in the last cycle of an operation. `line_oe` is never high while the block is idle.
- R8: The read word is registered. A read enable with address 0 returns {6'b0, busy, result} on the next cycle. A read of any other address returns 8'h00, and 8'h00 is also returned in any cycle that follows one without read enable.
- R9: A synchronous active-high reset returns the block to idle. The line is released, the busy flag is 0, read bit 0 is 1, and the read word is 8'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ren | input | 1 | Read enable |
| wen | input | 1 | Write enable |
| adr | input | ADDR_W (2) | Register address; only 0 is decoded |
| wdata | input | 8 | Control word |
| rdata | output | 8 | Registered read word: bit 1 busy, bit 0 result |
| line_oe | output | 1 | High pulls the bus wire low |
| line_in | input | 1 | Level of the bus wire |

## Verification
A new control write can land in the same clock cycle as the end of the running slot, when the sequencer clears its busy flag. The bench counts cycles from the accepting edge and places a second write in the last cycle in which busy is still 1. It checks that this write leaves the slot's busy and drive lengths unchanged and starts nothing. It then places a write one cycle later and checks that this one starts a new slot. A write that arrives part-way through a slot is judged the same way: the drive and busy lengths must stay exact.

// File: rtl/ow_pkg.sv
package ow_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RESET = 2'd1,
    SEQ_WRITE = 2'd2,
    SEQ_READ  = 2'd3
  } seq_mode_t;

  localparam logic [7:0] CTRL_BUS_RESET = 8'h0A;
  localparam logic [7:0] CTRL_WRITE0    = 8'h00;
  localparam logic [7:0] CTRL_WRITE1    = 8'h01;
  localparam logic [7:0] CTRL_READ      = 8'h02;

  // Map a control word to the operation it starts (SEQ_IDLE = not legal)
  function automatic seq_mode_t ctrl_decode(input logic [7:0] code);
    seq_mode_t m;
    case (code)
      CTRL_BUS_RESET:           m = SEQ_RESET;
      CTRL_WRITE0, CTRL_WRITE1: m = SEQ_WRITE;
      CTRL_READ:                m = SEQ_READ;
      default:                  m = SEQ_IDLE;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/ow_us_tick.sv
module ow_us_tick #(
  parameter int CLK_PER_US = 50
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int DIV_W = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div_cnt;

  // Restart aligns microsecond boundaries to the accepting edge
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      div_cnt <= '0;
    end else if (div_cnt == DIV_LAST) begin
      div_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign tick = (div_cnt == DIV_LAST);

  // R2
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    div_cnt <= DIV_LAST);

endmodule

// File: rtl/ow_line_sync.sv
module ow_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  output logic line_s
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= line_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], line_in};
      end
    end
  endgenerate

  assign line_s = chain[STAGES-1];

endmodule

// File: rtl/ow_slot_seq.sv
module ow_slot_seq
  import ow_pkg::*;
#(
  parameter int RST_LOW_US    = 480,
  parameter int RST_SAMPLE_US = 550,
  parameter int RST_TOTAL_US  = 960,
  parameter int SLOT_US       = 65,
  parameter int W1_LOW_US     = 6,
  parameter int W0_LOW_US     = 60,
  parameter int RD_LOW_US     = 6,
  parameter int RD_SAMPLE_US  = 15
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  seq_mode_t start_mode,
  input  logic      start_bit,
  input  logic      tick,
  input  logic      line_s,
  output logic      oe,
  output logic      busy,
  output logic      result
);
  localparam int US_MAX = (RST_TOTAL_US > SLOT_US) ? RST_TOTAL_US : SLOT_US;
  localparam int US_W   = $clog2(US_MAX + 1);

  seq_mode_t        mode;
  logic             wbit;
  logic [US_W-1:0]  us_cnt;
  logic [US_W-1:0]  us_nx;
  logic [US_W-1:0]  low_end;
  logic [US_W-1:0]  samp_at;
  logic [US_W-1:0]  end_at;
  logic             samp_en;

  // Per-mode timing points, in microseconds from the start
  always_comb begin
    us_nx   = us_cnt + 1'b1;
    low_end = US_W'(RD_LOW_US);
    samp_at = US_W'(RD_SAMPLE_US);
    end_at  = US_W'(SLOT_US);
    samp_en = 1'b0;
    case (mode)
      SEQ_RESET: begin
        low_end = US_W'(RST_LOW_US);
        samp_at = US_W'(RST_SAMPLE_US);
        end_at  = US_W'(RST_TOTAL_US);
        samp_en = 1'b1;
      end
      SEQ_WRITE: begin
        low_end = wbit ? US_W'(W1_LOW_US) : US_W'(W0_LOW_US);
      end
      SEQ_READ: begin
        samp_en = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode   <= SEQ_IDLE;
      wbit   <= 1'b0;
      us_cnt <= '0;
      oe     <= 1'b0;
      busy   <= 1'b0;
      result <= 1'b1;
    end else if (start && !busy) begin
      mode   <= start_mode;
      wbit   <= start_bit;
      us_cnt <= '0;
      oe     <= 1'b1;
      busy   <= 1'b1;
    end else if (busy && tick) begin
      us_cnt <= us_nx;
      if (us_nx == low_end) oe <= 1'b0;
      if (samp_en && (us_nx == samp_at)) result <= line_s;
      if (us_nx == end_at) begin
        busy <= 1'b0;
        mode <= SEQ_IDLE;
      end
    end
  end

  // R7
  idle_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !oe);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode));

  // R2
  us_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && (us_cnt != $past(us_cnt))) |-> $past(tick));

  // R5
  oe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(oe) && !$past(rst)) |-> $past(tick));

  // R9
  rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!oe && !busy && result));

endmodule

// File: rtl/ow_bus_master.sv
module ow_bus_master
  import ow_pkg::*;
#(
  parameter int CLK_PER_US  = 50,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ren,
  input  logic              wen,
  input  logic [ADDR_W-1:0] adr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              line_oe,
  input  logic              line_in
);
  seq_mode_t req_mode;
  logic      ctrl_sel;
  logic      accept;
  logic      tick;
  logic      line_s;
  logic      busy;
  logic      result;

  assign ctrl_sel = (adr == '0);
  assign req_mode = ctrl_decode(wdata);
  assign accept   = wen && ctrl_sel && (req_mode != SEQ_IDLE) && !busy;

  ow_us_tick #(
    .CLK_PER_US(CLK_PER_US)
  ) i_tick (
    .clk    (clk),
    .rst    (rst),
    .restart(accept),
    .tick   (tick)
  );

  ow_line_sync #(
    .STAGES(SYNC_STAGES)
  ) i_sync (
    .clk    (clk),
    .rst    (rst),
    .line_in(line_in),
    .line_s (line_s)
  );

  ow_slot_seq i_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .start_mode(req_mode),
    .start_bit (wdata[0]),
    .tick      (tick),
    .line_s    (line_s),
    .oe        (line_oe),
    .busy      (busy),
    .result    (result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= 8'h00;
    end else if (ren && ctrl_sel) begin
      rdata <= {6'b0, busy, result};
    end else begin
      rdata <= 8'h00;
    end
  end

  // R8
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ren) |-> (rdata == 8'h00));

  // R1
  foreign_adr_chk: assert property (@(posedge clk) disable iff (rst)
    (wen && !ctrl_sel && !busy) |=> !busy);

  // R1
  illegal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (wen && (req_mode == SEQ_IDLE) && !busy) |=> !busy);

endmodule

// File: tb/test_ow_bus_master.sv
module test_ow_bus_master;
  localparam int CPU = 50;

  typedef struct packed {
    logic [7:0] code;
    int         ds;
    int         de;
    int         exp_oe;
    int         exp_busy;
    logic       exp_bit;
  } vec_t;

  // Device pull-low window [ds, de) in microseconds from the start
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{8'h02, 0,   30,  300,   3250,  1'b0},  // R6 read, device holds 0
    '{8'h01, 0,   0,   300,   3250,  1'b0},  // R5 write 1, bit0 kept
    '{8'h00, 0,   0,   3000,  3250,  1'b0},  // R5 write 0, bit0 kept
    '{8'h02, 0,   0,   300,   3250,  1'b1},  // R6 read, released line
    '{8'h00, 0,   0,   3000,  3250,  1'b1},  // R5 write 0, bit0 kept
    '{8'h02, 20,  40,  300,   3250,  1'b1},  // R6 pull after sample point
    '{8'h02, 10,  30,  300,   3250,  1'b0},  // R6 pull spans sample point
    '{8'h0A, 510, 630, 24000, 48000, 1'b0}   // R3 R4 reset with presence
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ren = 1'b0;
  logic       wen = 1'b0;
  logic [1:0] adr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       line_oe;
  logic       dev_pull = 1'b0;
  wire        line_in = ~(line_oe | dev_pull);

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  ow_bus_master i_ow_bus_master (
    .clk    (clk),
    .rst    (rst),
    .ren    (ren),
    .wen    (wen),
    .adr    (adr),
    .wdata  (wdata),
    .rdata  (rdata),
    .line_oe(line_oe),
    .line_in(line_in)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Start one operation and count drive and busy cycles over len cycles
  task automatic run_slot(input logic [1:0] wadr, input logic [7:0] code,
                          input int ds, input int de, input int len,
                          input int inj_k, input logic [7:0] inj_code,
                          output int oe_n, output int busy_n,
                          output logic bit0, output logic busy_end);
    oe_n = 0;
    busy_n = 0;
    @(negedge clk);
    adr = wadr; wdata = code; wen = 1'b1; ren = 1'b1;
    @(negedge clk);
    wen = 1'b0; adr = 2'd0;
    for (int k = 0; k < len; k++) begin
      dev_pull = (k >= ds * CPU) && (k < de * CPU);
      if (k == inj_k) begin
        wen = 1'b1; wdata = inj_code;
      end else begin
        wen = 1'b0;
      end
      oe_n += int'(line_oe);
      busy_n += int'(rdata[1]);
      @(negedge clk);
    end
    wen = 1'b0;
    dev_pull = 1'b0;
    bit0 = rdata[0];
    busy_end = rdata[1];
    ren = 1'b0;
  endtask

  task automatic read_word(input logic [1:0] radr, output logic [7:0] val);
    @(negedge clk);
    adr = radr; ren = 1'b1;
    @(negedge clk);
    val = rdata;
    ren = 1'b0; adr = 2'd0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int oe_n, busy_n;
    logic b0, bend;
    logic [7:0] w;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 line released after reset", int'(line_oe), 0);
    read_word(2'd0, w);
    chk("R9 read word after reset", int'(w), 8'h01);
    @(negedge clk);
    chk("R8 read word without enable", int'(rdata), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      run_slot(2'd0, VEC[i].code, VEC[i].ds, VEC[i].de, VEC[i].exp_busy + 10,
               -1, 8'h00, oe_n, busy_n, b0, bend);
      chk($sformatf("R2 R3 R5 R6 drive cycles vec %0d", i), oe_n, VEC[i].exp_oe);
      chk($sformatf("R2 R3 R7 busy cycles vec %0d", i), busy_n, VEC[i].exp_busy);
      chk($sformatf("R4 R5 R6 bit0 vec %0d", i), int'(b0), int'(VEC[i].exp_bit));
    end

    // R4: reset with no device answering
    run_slot(2'd0, 8'h0A, 0, 0, 48010, -1, 8'h00, oe_n, busy_n, b0, bend);
    chk("R4 no presence bit0", int'(b0), 1);
    chk("R3 reset busy cycles", busy_n, 48000);

    // R7: reset request mid-slot is ignored
    run_slot(2'd0, 8'h01, 0, 0, 3260, 1000, 8'h0A, oe_n, busy_n, b0, bend);
    chk("R7 mid-slot write ignored drive", oe_n, 300);
    chk("R7 mid-slot write ignored busy", busy_n, 3250);

    // R7: write in the last busy cycle is ignored
    run_slot(2'd0, 8'h01, 0, 0, 3260, 3249, 8'h00, oe_n, busy_n, b0, bend);
    chk("R7 last-cycle write ignored busy", busy_n, 3250);
    chk("R7 last-cycle write ignored drive", oe_n, 300);
    chk("R7 idle after last-cycle write", int'(bend), 0);

    // R7: write one cycle later is accepted
    run_slot(2'd0, 8'h01, 0, 0, 3260, 3250, 8'h01, oe_n, busy_n, b0, bend);
    chk("R7 write after end accepted", int'(bend), 1);
    begin
      int guard = 0;
      @(negedge clk); ren = 1'b1;
      @(negedge clk);
      while (rdata[1] && guard < 4000) begin
        guard++;
        @(negedge clk);
      end
      ren = 1'b0;
      chk("R7 accepted slot finishes", int'(rdata[1]), 0);
    end

    // R1: illegal code and foreign address are ignored
    run_slot(2'd0, 8'h80, 0, 0, 20, -1, 8'h00, oe_n, busy_n, b0, bend);
    chk("R1 illegal code no busy", busy_n, 0);
    chk("R1 illegal code no drive", oe_n, 0);
    run_slot(2'd1, 8'h0A, 0, 0, 20, -1, 8'h00, oe_n, busy_n, b0, bend);
    chk("R1 foreign address no busy", busy_n, 0);
    chk("R1 foreign address no drive", oe_n, 0);

    // R8: read of another address returns zero
    read_word(2'd1, w);
    chk("R8 foreign address read", int'(w), 0);

    // R9: synchronous reset in the middle of a write-0 slot
    run_slot(2'd0, 8'h00, 0, 0, 100, -1, 8'h00, oe_n, busy_n, b0, bend);
    chk("R9 slot running before reset", int'(line_oe), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R9 line released by reset", int'(line_oe), 0);
    read_word(2'd0, w);
    chk("R9 idle word after reset", int'(w), 8'h01);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule